// File: doc/BRIEF.md
# SDRAM Truncated Read Sequencer

This block drives one SDR SDRAM read into a row that is already open and stops the burst early, so the memory returns exactly the number of words the requester asked for. A request names a bank, a column and a word count. The block puts a READ command on the pins. It counts out one issue slot per wanted word. When that count is used up it sends a BURST TERMINATE, unless the mode register's fixed burst would end at the right point anyway.

Data comes back CAS-latency cycles after the READ. The block captures it from the DQ bus and hands each word to the requester with a one-cycle valid strobe. A busy flag stays high until the last word is captured, and a one-cycle done pulse follows that word. The requester chooses a CAS latency of two or three. It also says whether the memory is set for continuous-page bursts or for a fixed length given by the `BURST_LEN` parameter.

Row activation, precharge scheduling, refresh, writes and initialization are handled elsewhere. Between its own commands the sequencer drives NOP.

Top module: `rd_trunc_seq`

## Requirements
- R1: One cycle after a request is accepted, the command pins carry READ (cs_n,ras_n,cas_n,we_n = 0,1,0,1). `sd_ba` carries the bank, `sd_addr[COL_W-1:0]` carries the column, and `sd_addr[10]` carries the auto-precharge flag.
- R2: When the read is truncated (continuous-page mode, or fixed mode with a count below `BURST_LEN`), BURST TERMINATE (0,1,1,0) appears exactly N cycles after the READ cycle for both CAS latencies. N is the requested count. This places it CL-1 cycles before the edge at which the last wanted word is valid.
- R3: On every other cycle, including the cycles during and after reset, the command pins carry NOP (0,1,1,1).
- R4: With the READ on the pins in cycle r, the first `rd_valid` appears in cycle r+CL+1. The strobes then run on consecutive cycles, and their number is exactly the delivered word count.
- R5: `rd_data` presents the words sampled from `sd_dq` in arrival order.
- R6: In fixed mode with a count of at least `BURST_LEN`, no BURST TERMINATE is sent and exactly `BURST_LEN` words are delivered. Auto-precharge is allowed in this case.
- R7: A request with a count of zero, or a truncated request that asks for auto-precharge, is refused. `req_err` pulses for one cycle, no READ is issued and `busy` stays low.
- R8: `sd_dqm` is all zeros from the READ cycle until the cycle in which the last word is captured. When the sequencer is idle it is all ones.
- R9: `busy` goes high the cycle after acceptance and falls in the cycle of the final `rd_valid`. A request raised while `busy` is high is ignored and issues no command.
- R10: `done` is a single-cycle pulse in the cycle right after the final `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; taken when busy is low |
| req_bank | input | BANK_W | Bank of the open row |
| req_col | input | COL_W | Starting column |
| req_len | input | CNT_W | Number of words wanted |
| req_autopre | input | 1 | Ask for auto-precharge on the READ |
| cfg_cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| cfg_page_burst | input | 1 | 1 = continuous-page bursts, 0 = fixed length BURST_LEN |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address pins |
| sd_addr | output | ADDR_W | Address pins |
| sd_dqm | output | DATA_W/8 | Byte masks |
| sd_dq | input | DATA_W | Data from the SDRAM |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | rd_data holds a new word |
| busy | output | 1 | A read is in progress |
| done | output | 1 | Pulse after the final word |
| req_err | output | 1 | Pulse when a request is refused |

## Verification
The errors that matter most are a slot counter or a valid pipeline that is off by one. Either one shows at the ports within a few cycles of the READ. The terminate moves away from READ+N, or the first strobe moves away from READ+CL+1. The bench memory model stops driving real data at the point the terminate implies, so a mistimed terminate also yields wrong or extra words. A word counter that loses track shows as the wrong number of strobes, or as done and busy arriving late or never.

// File: rtl/rts_pkg.sv
package rts_pkg;

    // Largest CAS latency supported by the capture pipeline.
    localparam int MAX_CL = 3;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_READ = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_BST  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    // Latency in clock cycles selected by the CL flag.
    function automatic logic [1:0] cl_cycles(input logic cl3);
        return cl3 ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/rts_issue.sv
module rts_issue
    import rts_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  n_slots,
    input  logic              need_term,
    input  logic              autopre,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    output sd_cmd_t           cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              slot
);

    logic             issuing;
    logic [CNT_W-1:0] slots_left;
    logic             term_pend;
    logic [ADDR_W-1:0] rd_addr;

    // Column in the low bits, auto-precharge on A10.
    always_comb begin
        rd_addr              = '0;
        rd_addr[COL_W-1:0]   = col;
        rd_addr[10]          = autopre;
    end

    // One slot per wanted word, the first on the accept edge.
    assign slot = start | (issuing && (slots_left != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd        <= CMD_NOP;
            ba         <= '0;
            addr       <= '0;
            issuing    <= 1'b0;
            slots_left <= '0;
            term_pend  <= 1'b0;
        end else begin
            cmd  <= CMD_NOP;
            ba   <= '0;
            addr <= '0;
            if (start) begin
                cmd        <= CMD_READ;
                ba         <= bank;
                addr       <= rd_addr;
                issuing    <= 1'b1;
                slots_left <= n_slots - 1'b1;
                term_pend  <= need_term;
            end else if (issuing) begin
                if (slots_left != '0) begin
                    slots_left <= slots_left - 1'b1;
                end else begin
                    // N cycles after the READ: terminate if truncating
                    issuing   <= 1'b0;
                    term_pend <= 1'b0;
                    if (term_pend) cmd <= CMD_BST;
                end
            end
        end
    end

    // R1: a READ is never followed directly by another READ
    a_r1_single_read: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ) |=> (cmd != CMD_READ));

    // R2: the terminate goes out only once all slots are spent
    a_r2_term_after_slots: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BST) |-> (!slot && !issuing));

endmodule

// File: rtl/rts_capture.sv
module rts_capture
    import rts_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cl3,
    input  logic              slot,
    input  logic [CNT_W-1:0]  n_words,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cap_en,
    output logic              cap_last
);

    logic [MAX_CL:0]  vpipe;
    logic             cl3_q;
    logic [CNT_W-1:0] words_left;

    // A slot launched at edge e is sampled on the DQ bus at edge e+CL+1.
    assign cap_en   = vpipe[cl_cycles(cl3_q)];
    assign cap_last = cap_en && (words_left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe      <= '0;
            cl3_q      <= 1'b0;
            words_left <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            vpipe    <= {vpipe[MAX_CL-1:0], slot};
            rd_valid <= cap_en;
            if (cap_en) begin
                rd_data    <= dq;
                words_left <= words_left - 1'b1;
            end
            if (start) begin
                cl3_q      <= cl3;
                words_left <= n_words;
            end
        end
    end

    // R4: never capture more words than were requested
    a_r4_no_extra_word: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (words_left != '0));

endmodule

// File: rtl/rd_trunc_seq.sv
module rd_trunc_seq
    import rts_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 6,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [CNT_W-1:0]  req_len,
    input  logic              req_autopre,
    input  logic              cfg_cl3,
    input  logic              cfg_page_burst,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W/8-1:0] sd_dqm,
    input  logic [DATA_W-1:0] sd_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              req_err
);

    localparam int               DQM_W = DATA_W / 8;
    localparam logic [CNT_W-1:0] BL_C  = CNT_W'(BURST_LEN);

    sd_cmd_t          cmd;
    logic             run;
    logic             fin_q;
    logic             need_term;
    logic             bad_req;
    logic             start;
    logic [CNT_W-1:0] n_eff;
    logic             slot;
    logic             cap_en;
    logic             cap_last;

    // Truncation needed unless a fixed burst ends exactly where wanted.
    assign need_term = cfg_page_burst || (req_len < BL_C);
    assign n_eff     = need_term ? req_len : BL_C;
    assign bad_req   = (req_len == '0) || (need_term && req_autopre);
    assign start     = req_valid && !run && !bad_req;

    rts_issue #(
        .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .CNT_W(CNT_W)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .n_slots   (n_eff),
        .need_term (need_term),
        .autopre   (req_autopre),
        .bank      (req_bank),
        .col       (req_col),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .slot      (slot)
    );

    rts_capture #(
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cl3      (cfg_cl3),
        .slot     (slot),
        .n_words  (n_eff),
        .dq       (sd_dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .cap_en   (cap_en),
        .cap_last (cap_last)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign busy     = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            fin_q   <= 1'b0;
            done    <= 1'b0;
            req_err <= 1'b0;
            sd_dqm  <= {DQM_W{1'b1}};
        end else begin
            fin_q   <= cap_last;
            done    <= fin_q;
            req_err <= req_valid && !run && bad_req;
            if (start) begin
                run    <= 1'b1;
                sd_dqm <= '0;
            end else if (cap_last) begin
                run    <= 1'b0;
                sd_dqm <= {DQM_W{1'b1}};
            end
        end
    end

    // R8: masks are open whenever a word is being sampled
    a_r8_dqm_low_on_capture: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> (sd_dqm == '0));

    // R7: a refused request issues no command
    a_r7_reject_no_read: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (cmd == CMD_NOP));

    // R10: done only directly after a delivered word
    a_r10_done_after_word: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_valid));

    // R9: no new READ while a previous one is still being collected
    a_r9_no_read_when_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ) |-> !$past(run));

endmodule

// File: tb/rd_trunc_seq_test.sv
module rd_trunc_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int BL         = 8;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_col = '0;
    logic [5:0]  req_len = '0;
    logic        req_autopre = 1'b0;
    logic        cfg_cl3 = 1'b0;
    logic        cfg_page_burst = 1'b1;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] dq_drv = 16'hDEAD;
    logic [15:0] rd_data;
    logic        rd_valid, busy, done, req_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int idx = 0;

    // monitor log
    int read_cnt, bst_cnt, bad_cmd, val_cnt, done_cnt, err_cnt, dqm_bad;
    int rd_idx, bst_idx, first_val, last_val, done_idx;
    logic [1:0]  rd_ba;
    logic [11:0] rd_addr;
    logic [15:0] val_data [64];
    int exp_cl = 2;
    int exp_nw = 0;
    bit exp_page = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_trunc_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_len(req_len), .req_autopre(req_autopre),
        .cfg_cl3(cfg_cl3), .cfg_page_burst(cfg_page_burst),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq(dq_drv),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .req_err(req_err)
    );

    function automatic logic [15:0] pat(input logic [1:0] b, input logic [7:0] c);
        return {b, 6'h15, c};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_log;
        read_cnt = 0; bst_cnt = 0; bad_cmd = 0; val_cnt = 0; done_cnt = 0;
        err_cnt = 0; dqm_bad = 0; rd_idx = -1; bst_idx = -1; first_val = -1;
        last_val = -1; done_idx = -1;
    endtask

    // Pin monitor and SDRAM data model, evaluated between clock edges.
    always @(negedge clk) begin
        logic [3:0] c;
        int k;
        bit ok;
        idx++;
        if (!rst) begin
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (c == 4'b0101) begin
                read_cnt++; rd_idx = idx; rd_ba = sd_ba; rd_addr = sd_addr;
            end else if (c == 4'b0110) begin
                bst_cnt++; bst_idx = idx;
            end else if (c != 4'b0111) begin
                bad_cmd++;
            end
            if (rd_valid) begin
                if (val_cnt < 64) val_data[val_cnt] = rd_data;
                if (val_cnt == 0) first_val = idx;
                last_val = idx;
                val_cnt++;
            end
            if (done) begin done_cnt++; done_idx = idx; end
            if (req_err) err_cnt++;
            if (rd_idx >= 0 && idx >= rd_idx && idx <= rd_idx + exp_cl + exp_nw - 1 && sd_dqm != 2'b00)
                dqm_bad++;
            dq_drv = 16'hDEAD;
            if (rd_idx >= 0) begin
                k  = idx - rd_idx - exp_cl;
                ok = (k >= 0);
                if (bst_idx >= 0 && idx > bst_idx + exp_cl - 1) ok = 1'b0;
                if (!exp_page && k >= BL) ok = 1'b0;
                if (ok) dq_drv = pat(rd_ba, rd_addr[7:0] + 8'(k));
            end
        end else begin
            c = 4'b0111;
            k = 0;
            ok = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic t_reset;
        @(posedge clk); #(CLK_PERIOD/4);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R3 NOP in reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        rst = 1'b0;
        repeat (2) @(posedge clk); #(CLK_PERIOD/4);
        chk(!busy && !rd_valid && !done, "R9 idle after reset", int'({busy, rd_valid, done}), 0);
        chk(sd_dqm == 2'b11, "R8 masks high when idle", int'(sd_dqm), 3);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R3 NOP after reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    endtask

    // Generic truncated/fixed read with full port-level checking.
    task automatic t_read(input logic [1:0] b, input logic [7:0] col, input int n,
                          input bit page, input bit cl3, input bit ap, input bit poke,
                          input string name);
        int nw;
        bit term;
        int mism;
        term = page || (n < BL);
        nw   = term ? n : BL;
        @(posedge clk);
        clear_log();
        exp_cl = cl3 ? 3 : 2; exp_page = page; exp_nw = nw;
        @(negedge clk);
        req_bank = b; req_col = col; req_len = 6'(n); req_autopre = ap;
        cfg_cl3 = cl3; cfg_page_burst = page; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R9: a second request during the run must be ignored
            @(negedge clk);
            req_col = col + 8'd40; req_autopre = 1'b0; req_valid = 1'b1;
            @(posedge clk); #(CLK_PERIOD/4);
            chk(busy, {"R9 busy during run ", name}, int'(busy), 1);
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 100 && done_cnt == 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk(read_cnt == 1, {"R1 one READ ", name}, read_cnt, 1);
        chk(rd_ba == b && rd_addr[7:0] == col && rd_addr[10] == ap, {"R1 READ address ", name},
            int'({rd_ba, rd_addr}), int'({b, 1'b0, ap, 2'b00, col}));
        if (term) begin
            chk(bst_cnt == 1 && bst_idx == rd_idx + n, {"R2 terminate timing ", name},
                bst_idx - rd_idx, n);
        end else begin
            chk(bst_cnt == 0, {"R6 no terminate ", name}, bst_cnt, 0);
        end
        chk(val_cnt == nw, {"R4 word count ", name}, val_cnt, nw);
        chk(first_val == rd_idx + exp_cl + 1, {"R4 first word latency ", name},
            first_val - rd_idx, exp_cl + 1);
        chk(last_val == first_val + nw - 1, {"R4 consecutive strobes ", name},
            last_val - first_val + 1, nw);
        mism = 0;
        for (int k = 0; k < nw && k < 64; k++)
            if (val_data[k] != pat(b, col + 8'(k))) mism++;
        chk(mism == 0, {"R5 data order ", name}, mism, 0);
        chk(done_cnt == 1 && done_idx == last_val + 1, {"R10 done pulse ", name},
            done_idx - last_val, 1);
        chk(dqm_bad == 0 && sd_dqm == 2'b11, {"R8 mask window ", name}, dqm_bad, 0);
        chk(bad_cmd == 0 && !busy, {"R3 only NOP otherwise ", name}, bad_cmd, 0);
    endtask

    task automatic t_reject(input int n, input bit page, input string name);
        @(posedge clk);
        clear_log();
        @(negedge clk);
        req_bank = 2'd1; req_col = 8'd8; req_len = 6'(n); req_autopre = 1'b1;
        cfg_page_burst = page; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_autopre = 1'b0;
        repeat (6) @(posedge clk);
        #(CLK_PERIOD/4);
        chk(err_cnt == 1, {"R7 refusal pulse ", name}, err_cnt, 1);
        chk(read_cnt == 0 && bst_cnt == 0 && !busy, {"R7 no READ issued ", name}, read_cnt, 0);
    endtask

    initial begin
        clear_log();
        t_reset();
        t_read(2'd0, 8'd16, 4,  1'b1, 1'b0, 1'b0, 1'b0, "page CL2 N4");
        t_read(2'd1, 8'd32, 4,  1'b1, 1'b1, 1'b0, 1'b0, "page CL3 N4");
        t_read(2'd2, 8'd48, 1,  1'b1, 1'b1, 1'b0, 1'b0, "page CL3 N1");
        t_read(2'd3, 8'd64, 1,  1'b1, 1'b0, 1'b0, 1'b0, "page CL2 N1");
        t_read(2'd1, 8'd80, 20, 1'b1, 1'b0, 1'b0, 1'b0, "page CL2 N20");
        t_read(2'd2, 8'd96, 3,  1'b0, 1'b1, 1'b0, 1'b0, "fixed CL3 N3");
        t_read(2'd0, 8'd104, 7, 1'b0, 1'b0, 1'b0, 1'b0, "fixed CL2 N7");
        t_read(2'd3, 8'd120, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R6 fixed CL2 N8 autopre");
        t_read(2'd0, 8'd136, 12, 1'b0, 1'b1, 1'b0, 1'b0, "R6 fixed CL3 N12 clipped");
        t_read(2'd1, 8'd152, 10, 1'b1, 1'b1, 1'b0, 1'b1, "R9 busy ignore");
        t_reject(3, 1'b0, "fixed N3 autopre");
        t_reject(5, 1'b1, "page autopre");
        t_reject(0, 1'b0, "zero count");
        t_read(2'd2, 8'd168, 5,  1'b1, 1'b0, 1'b0, 1'b0, "after refusals");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule